// File: doc/BRIEF.md
# I2C Serial EEPROM Target Model

This block is a synthesizable I2C target that stores 256 bytes and answers on the bus the way a small serial EEPROM does. The bus lines come in as open-drain inputs (`scl_i`, `sda_i`), and the block answers through a single pull-low output (`sda_pull_o`). Both lines pass through a two-stage synchronizer into the system clock domain. SCL edges, START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high) are detected there. SDA is sampled when SCL rises. The driven SDA changes only after SCL has fallen.

A controller selects the target with the address byte `1010_000x`. Bit 0 of that byte is 0 for a write and 1 for a read. A write carries one word-address byte and then any number of data bytes. A read returns bytes starting at the internal address counter. A random read sets that counter with a write of the word address alone, then sends a repeated START and the read address. The counter is kept from one transaction to the next. Data writes advance the counter only inside the current 8-byte page. Reads advance it through the whole 256-byte range, and 0xFF rolls over to 0x00.

The state machine has these states:
- `ST_IDLE`: waiting for a START.
- `ST_DEV`: receiving the address byte.
- `ST_DEV_ACK`: acknowledging the address byte.
- `ST_WADDR`: receiving the word address.
- `ST_WADDR_ACK`: acknowledging the word address.
- `ST_WDATA`: receiving a data byte.
- `ST_WDATA_ACK`: acknowledging a data byte.
- `ST_RDATA`: shifting out a read byte.
- `ST_RACK`: sampling the controller's acknowledge.
- `ST_IGNORE`: ignoring the bus.

Its transitions are these:
- A START leads from any state to `ST_DEV`, and a STOP leads from any state to `ST_IDLE`.
- In `ST_DEV`, a matching byte leads to `ST_DEV_ACK`, and any other byte leads to `ST_IGNORE`.
- From `ST_DEV_ACK`, a read goes to `ST_RDATA` and a write goes to `ST_WADDR`.
- The path `ST_WADDR` → `ST_WADDR_ACK` → `ST_WDATA` is taken once.
- The pair `ST_WDATA` → `ST_WDATA_ACK` repeats for each data byte.
- `ST_RDATA` goes to `ST_RACK` after the 8th bit.
- From `ST_RACK`, an ACK leads back to `ST_RDATA`, and a NACK leads to `ST_IGNORE`.

Top module: `i2c_eeprom_target`

## Requirements
- R1: After reset `sda_pull_o` is 0 (SDA released), the address counter is 0x00 and every stored byte reads 0x00.
- R2: A START from any state makes the next 8 bits an address byte. A STOP ends any transfer and releases SDA.
- R3: An address byte equal to 0xA0 (write) or 0xA1 (read) is acknowledged: the target pulls SDA low during the 9th SCL clock.
- R4: An address byte with any other upper seven bits is not acknowledged. Until the next START, the target drives nothing and the stored bytes do not change.
- R5: A byte write consists of START, 0xA0, a word address, one data byte and STOP. It stores the data byte at the word address and acknowledges all three bytes.
- R6: In a page write, each further data byte goes to the next location of the same 8-byte page. After offset 7 the next location is offset 0 of that page, and earlier bytes there are overwritten.
- R7: A random read consists of START, 0xA0, a word address, a repeated START and 0xA1. It returns the byte stored at that word address.
- R8: A current-address read (START, 0xA1) returns the byte at the address counter. The counter advances by one after every byte read. After a write, the counter points to the location that follows the last byte written, within that byte's page.
- R9: While the controller acknowledges each byte, a read keeps returning successive bytes, and the address wraps from 0xFF to 0x00.
- R10: After the controller answers a read byte with NACK, the target stops driving SDA until the next START, and the counter does not advance again.
- R11: `sda_pull_o` changes only while the synchronized SCL is low, apart from the release forced by START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed level of the open-drain SCL line |
| sda_i | input | 1 | Sensed level of the open-drain SDA line |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions check the following on every cycle:
- START moves the machine to `ST_DEV`.
- STOP returns it to `ST_IDLE` with SDA released.
- SDA stays released in `ST_IGNORE`.
- Data writes never leave the current page.
- Every entry to `ST_RDATA` advances the counter by one.
- The driven SDA changes only while SCL is low.

Only the bench's scenarios can show the following:
- Which bytes come back, and whether each acknowledge is correct.
- The wrap inside a page during writes.
- The 0xFF-to-0x00 rollover on reads.
- That an address which does not match leaves memory untouched.
- That the counter is kept across separate transactions.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } eep_state_e;

    function automatic logic is_rx_state(eep_state_e s);
        return (s == ST_DEV) || (s == ST_WADDR) || (s == ST_WDATA);
    endfunction

    function automatic logic is_ack_state(eep_state_e s);
        return (s == ST_DEV_ACK) || (s == ST_WADDR_ACK) || (s == ST_WDATA_ACK);
    endfunction

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    localparam int LINES = 2;

    logic [LINES-1:0] line_in;
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] line_q;

    assign line_in = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], line_in[g]};
                end
            end
            assign line_s[g] = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q <= '1;
        end else begin
            line_q <= line_s;
        end
    end

    assign scl_s     = line_s[0];
    assign sda_s     = line_s[1];
    assign scl_rise  =  line_s[0] & ~line_q[0];
    assign scl_fall  = ~line_s[0] &  line_q[0];
    assign start_evt =  line_s[0] &  line_q[0] &  line_q[1] & ~line_s[1];
    assign stop_evt  =  line_s[0] &  line_q[0] & ~line_q[1] &  line_s[1];

endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
    parameter int DEPTH = 256,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (wr_en) begin
            cells[wr_addr] <= wr_data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/eep_fsm.sv
module eep_fsm
    import eep_pkg::*;
#(
    parameter int         AW         = 8,
    parameter int         PAGE_BYTES = 8,
    parameter logic [3:0] DEV_PREFIX = 4'b1010,
    parameter logic [2:0] DEV_STRAP  = 3'b000,
    localparam int        PW         = $clog2(PAGE_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sda_s,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_evt,
    input  logic          stop_evt,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [AW-1:0] ptr,
    output logic [7:0]    wr_data,
    output logic          sda_pull,
    output eep_state_e    state
);

    eep_state_e    state_d;
    logic [2:0]    cnt, cnt_d;
    logic [7:0]    shreg, shreg_d;
    logic [AW-1:0] ptr_d;
    logic          full, full_d;
    logic          rw, rw_d;
    logic          nack, nack_d;
    logic          pull_d;

    // Next state and datapath
    always_comb begin
        state_d = state;
        cnt_d   = cnt;
        shreg_d = shreg;
        ptr_d   = ptr;
        full_d  = full;
        rw_d    = rw;
        nack_d  = nack;
        wr_en   = 1'b0;

        if (start_evt) begin
            state_d = ST_DEV;
            cnt_d   = '0;
            full_d  = 1'b0;
        end else if (stop_evt) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            full_d  = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                end
                ST_DEV, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg_d = {shreg[6:0], sda_s};
                        cnt_d   = cnt + 3'd1;
                        if (cnt == 3'd7) begin
                            full_d = 1'b1;
                        end
                    end else if (scl_fall && full) begin
                        full_d = 1'b0;
                        cnt_d  = '0;
                        if (state == ST_DEV) begin
                            if (shreg[7:1] == {DEV_PREFIX, DEV_STRAP}) begin
                                rw_d    = shreg[0];
                                state_d = ST_DEV_ACK;
                            end else begin
                                state_d = ST_IGNORE;
                            end
                        end else if (state == ST_WADDR) begin
                            ptr_d   = shreg[AW-1:0];
                            state_d = ST_WADDR_ACK;
                        end else begin
                            wr_en   = 1'b1;
                            ptr_d   = {ptr[AW-1:PW], ptr[PW-1:0] + 1'b1};
                            state_d = ST_WDATA_ACK;
                        end
                    end
                end
                ST_DEV_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rw) begin
                            shreg_d = rd_data;
                            ptr_d   = ptr + 1'b1;
                            state_d = ST_RDATA;
                        end else begin
                            state_d = ST_WADDR;
                        end
                    end
                end
                ST_WADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_d   = '0;
                        state_d = ST_WDATA;
                    end
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) begin
                        cnt_d   = '0;
                        state_d = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (cnt == 3'd7) begin
                            cnt_d   = '0;
                            state_d = ST_RACK;
                        end else begin
                            shreg_d = {shreg[6:0], 1'b1};
                            cnt_d   = cnt + 3'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        nack_d = sda_s;
                    end else if (scl_fall) begin
                        if (nack) begin
                            state_d = ST_IGNORE;
                        end else begin
                            shreg_d = rd_data;
                            ptr_d   = ptr + 1'b1;
                            cnt_d   = '0;
                            state_d = ST_RDATA;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            ptr   <= '0;
            full  <= 1'b0;
            rw    <= 1'b0;
            nack  <= 1'b0;
        end else begin
            state <= state_d;
            cnt   <= cnt_d;
            shreg <= shreg_d;
            ptr   <= ptr_d;
            full  <= full_d;
            rw    <= rw_d;
            nack  <= nack_d;
        end
    end

    // Output decode, registered so the pin moves only with state changes
    always_comb begin
        pull_d = 1'b0;
        if (is_ack_state(state_d)) begin
            pull_d = 1'b1;
        end else if (state_d == ST_RDATA) begin
            pull_d = ~shreg_d[7];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
        end else begin
            sda_pull <= pull_d;
        end
    end

    assign wr_data = shreg;

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import eep_pkg::*;
#(
    parameter int         MEM_BYTES   = 256,
    parameter int         PAGE_BYTES  = 8,
    parameter logic [3:0] DEV_PREFIX  = 4'b1010,
    parameter logic [2:0] DEV_STRAP   = 3'b000,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o
);

    localparam int AW = $clog2(MEM_BYTES);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic          wr_en;
    logic [AW-1:0] ptr;
    logic [7:0]    wr_data, rd_data;
    eep_state_e    state;

    eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    eep_fsm #(
        .AW         (AW),
        .PAGE_BYTES (PAGE_BYTES),
        .DEV_PREFIX (DEV_PREFIX),
        .DEV_STRAP  (DEV_STRAP)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .ptr       (ptr),
        .wr_data   (wr_data),
        .sda_pull  (sda_pull_o),
        .state     (state)
    );

    eep_mem #(.DEPTH(MEM_BYTES), .DW(8)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (ptr),
        .wr_data (wr_data),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/eep_checker.sv
module eep_checker
    import eep_pkg::*;
#(
    parameter int AW = 8,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_s,
    input logic          start_evt,
    input logic          stop_evt,
    input logic          wr_en,
    input logic [AW-1:0] ptr,
    input eep_state_e    state,
    input logic          sda_pull_o
);

    AST_START_TO_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (state == ST_DEV)); // R2

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state == ST_IDLE && !sda_pull_o)); // R2

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pull_o); // R4

    AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr[AW-1:PW] == $past(ptr[AW-1:PW]))); // R6

    AST_READ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RDATA && $past(state) != ST_RDATA) |-> (ptr == $past(ptr) + 1'b1)); // R8

    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> (!scl_s || $past(start_evt) || $past(stop_evt))); // R11

endmodule

bind i2c_eeprom_target eep_checker #(
    .AW ($clog2(MEM_BYTES)),
    .PW ($clog2(PAGE_BYTES))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_s      (scl_s),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .wr_en      (wr_en),
    .ptr        (ptr),
    .state      (state),
    .sda_pull_o (sda_pull_o)
);

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    always #10 clk = ~clk;

    i2c_eeprom_target u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull)
    );

    int tests = 0;
    int fails = 0;
    int viol  = 0;
    int ref_mem [256];
    int ref_ptr = 0;
    int exp_q [$];
    string req_q [$];
    int obs_val;
    event obs_ev;

    task automatic chk(input int act, input int exp, input string req);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic push_exp(input int v, input string req);
        exp_q.push_back(v);
        req_q.push_back(req);
    endtask

    task automatic observe(input int v);
        obs_val = v;
        ->obs_ev;
        #1;
    endtask

    // Monitor: pops expected items as results appear on the bus
    initial begin
        forever begin
            @(obs_ev);
            if (exp_q.size() == 0) begin
                chk(obs_val, -1, "SCOREBOARD");
            end else begin
                chk(obs_val, exp_q.pop_front(), req_q.pop_front());
            end
        end
    end

    // R11: the target must not move SDA while SCL is high
    always @(sda_pull) begin
        if (rst_n && scl_m) viol++;
    end

    task automatic q();
        repeat (8) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        sda_m = 1'b0; q();
        scl_m = 1'b0; q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; q();
        scl_m = 1'b1; q();
        sda_m = 1'b1; q();
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; q();
            scl_m = 1'b1; q(); q();
            scl_m = 1'b0; q();
        end
        sda_m = 1'b1; q();
        scl_m = 1'b1; q();
        ack = sda_line; q();
        scl_m = 1'b0; q();
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q();
            scl_m = 1'b1; q();
            b[i] = sda_line; q();
            scl_m = 1'b0;
        end
        sda_m = mack; q();
        scl_m = 1'b1; q(); q();
        scl_m = 1'b0; q();
        sda_m = 1'b1;
    endtask

    task automatic send(input logic [7:0] b, input int exp_ack, input string req);
        logic a;
        push_exp(exp_ack, req);
        write_byte(b, a);
        observe(int'(a));
    endtask

    task automatic recv(input logic mack, input string req);
        logic [7:0] v;
        push_exp(ref_mem[ref_ptr], req);
        ref_ptr = (ref_ptr + 1) % 256;
        read_byte(mack, v);
        observe(int'(v));
    endtask

    task automatic wr_data_byte(input logic [7:0] d, input string req);
        send(d, 0, req);
        ref_mem[ref_ptr] = d;
        ref_ptr = (ref_ptr & 8'hF8) | ((ref_ptr + 1) & 7);
    endtask

    task automatic wr_begin(input logic [7:0] addr, input string req);
        bus_start();
        send(8'hA0, 0, "R3");
        send(addr, 0, req);
        ref_ptr = addr;
    endtask

    task automatic rand_read(input logic [7:0] addr, input int n, input string req);
        wr_begin(addr, req);
        bus_start();
        send(8'hA1, 0, "R3");
        for (int k = 0; k < n; k++) recv(k == n - 1, req);
        bus_stop();
    endtask

    task automatic cur_read(input int n, input string req);
        bus_start();
        send(8'hA1, 0, "R3");
        for (int k = 0; k < n; k++) recv(k == n - 1, req);
        bus_stop();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 256; i++) ref_mem[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(int'(sda_pull), 0, "R1 released after reset");

        // R1 / R8: current read after reset returns location 0
        cur_read(1, "R1");

        // R5 byte write, then R7 random read
        wr_begin(8'h10, "R5");
        wr_data_byte(8'h5A, "R5");
        bus_stop();
        rand_read(8'h10, 1, "R7");

        // R6 page write crossing the page end
        wr_begin(8'h1E, "R6");
        for (int k = 0; k < 5; k++) wr_data_byte(8'hB0 + 8'(k), "R6");
        bus_stop();
        // R8 counter after write sits inside the page: 0x1B
        cur_read(1, "R8");
        rand_read(8'h18, 8, "R9");
        // R8 counter persisted past the sequential read
        cur_read(1, "R8");

        // R4 address mismatch: no ack, no write
        bus_start();
        send(8'hA2, 1, "R4");
        send(8'h10, 1, "R4");
        send(8'hFF, 1, "R4");
        bus_stop();
        rand_read(8'h10, 1, "R4");

        // R9 read rollover 0xFF -> 0x00
        wr_begin(8'hFF, "R9");
        wr_data_byte(8'hC3, "R9");
        bus_stop();
        wr_begin(8'h00, "R9");
        wr_data_byte(8'h3C, "R9");
        bus_stop();
        rand_read(8'hFF, 2, "R9");

        // R10 after NACK the target stays off the bus
        bus_start();
        send(8'hA1, 0, "R3");
        recv(1'b1, "R10");
        push_exp(8'hFF, "R10");
        read_byte(1'b1, v);
        observe(int'(v));
        bus_stop();
        cur_read(1, "R10");

        // R2 repeated START in the middle of a write
        wr_begin(8'h40, "R2");
        wr_data_byte(8'h11, "R2");
        bus_start();
        send(8'hA1, 0, "R2");
        recv(1'b1, "R2");
        bus_stop();
        q();
        chk(int'(sda_pull), 0, "R2 released after stop");
        rand_read(8'h40, 1, "R2");

        chk(viol, 0, "R11 sda moved while scl high");
        q(); q();
        chk(exp_q.size(), 0, "SCOREBOARD drained");
        summary();
        $finish;
    end

endmodule